// File: doc/BRIEF.md
# Codec Conversion Timing Generator

This block produces the frame timing for an audio codec that runs as a master or stand-alone unit. A programmable divider of the master clock makes a tick pair, and every second tick is a filter-clock (FCLK) enable. A down-counter stepped by FCLK sets the length of one frame. The block has no derived clocks. FCLK, the frame counter and all strobes live in the master-clock domain as single-cycle enables.

Within each frame the block issues several one-cycle strobes. The analog-to-digital conversion starts at a fixed count near the end of the frame and completes when the frame ends. An active-low frame sync is then timed to the edges of an externally supplied shift clock. The digital-to-analog conversion starts together with the frame sync and completes ten FCLK periods later. The divider and frame-length settings are taken only at frame boundaries, so a change never breaks a running frame.

Top module: `codec_frame_timer`

## Requirements
- R1: `fclk_tick` pulses for one master cycle once every 2*A master cycles, where A is the captured divider setting and a setting of 0 acts as 1.
- R2: `b_cnt` holds its value except in a cycle that follows a `fclk_tick` pulse. There it drops by one, or it reloads to B-1 after showing 0, so one frame lasts 2*A*B master cycles.
- R3: `a_div` and `b_len` are captured only at reset and at the end of a frame (the tick that ends the zero count). A `b_len` below 20 is used as 20.
- R4: `adc_start` pulses for one cycle in the first cycle that `b_cnt` shows 9, that is 2*A*(B-10) cycles after the frame starts.
- R5: `adc_done` pulses for one cycle at the end of the frame, exactly 10 FCLK ticks after `adc_start`. In that cycle `b_cnt` shows the reloaded value B-1.
- R6: `sclk_in` passes through two synchronizer stages and one edge register, so a level change driven between clock edges is acted on at the third following edge. After a frame ends, the first falling edge acted on at a later edge arms the sync, and the next rising edge drives `fs_n` low.
- R7: `fs_n` stays low for exactly one SCLK period, rising edge to rising edge, and then returns high. The end of a frame forces it high and restarts the arming.
- R8: `dac_start` pulses in the cycle that `fs_n` first shows low. `dac_done` pulses 10 FCLK ticks later.
- R9: While `rst` is high, `fs_n` is 1, all strobes are 0 and `b_cnt` equals the clamped `b_len` minus 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst | input | 1 | synchronous active-high reset |
| sclk_in | input | 1 | external shift clock, asynchronous level |
| a_div | input | AW | master-clock divider setting |
| b_len | input | BW | frame length in FCLK periods |
| fclk_tick | output | 1 | filter-clock enable pulse |
| b_cnt | output | BW | frame down-counter |
| adc_start | output | 1 | ADC conversion start strobe |
| adc_done | output | 1 | ADC conversion complete strobe (frame end) |
| dac_start | output | 1 | DAC conversion start strobe |
| dac_done | output | 1 | DAC conversion complete strobe |
| fs_n | output | 1 | active-low frame sync |

## Verification
The bench builds the block with its default widths, which are 8-bit divider and frame registers, a 20-count frame floor, an ADC start at count 9 and 10-tick conversions. Stimulus limits the divider to 0..3 and the frame length to 0..40, and the shift clock uses random half periods of one to three master cycles. These limits keep frames short, so many frame ends, clamp events, zero-divider cases and mid-frame setting changes occur within the run. The shift-clock edges fall at every phase relative to the frame end, including edges in the very cycle the frame ends.

// File: rtl/codec_frame_timer.sv
module codec_frame_timer #(
  parameter int AW       = 8,
  parameter int BW       = 8,
  parameter int BMIN     = 20,
  parameter int ADC_AT   = 9,
  parameter int CONV_LEN = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk_in,
  input  logic [AW-1:0] a_div,
  input  logic [BW-1:0] b_len,
  output logic          fclk_tick,
  output logic [BW-1:0] b_cnt,
  output logic          adc_start,
  output logic          adc_done,
  output logic          dac_start,
  output logic          dac_done,
  output logic          fs_n
);
  localparam int CW = $clog2(CONV_LEN + 1);

  typedef enum logic [1:0] {S_IDLE, S_WFALL, S_WRISE, S_LOW} fs_state_t;

  logic [AW-1:0] a_q, a_cnt;
  logic          phase;
  logic [CW-1:0] dac_left;
  logic          s1, s2, s3;
  fs_state_t     state;

  wire [AW-1:0] a_eff   = (a_div == '0) ? AW'(1) : a_div;
  wire [BW-1:0] b_eff   = (b_len < BW'(BMIN)) ? BW'(BMIN) : b_len;
  wire [BW-1:0] b_load  = b_eff - 1'b1;
  wire          a_wrap  = (a_cnt == a_q - 1'b1);
  wire          b_end   = fclk_tick && (b_cnt == '0);
  wire          sc_rise = s2 & ~s3;
  wire          sc_fall = ~s2 & s3;

  assign fclk_tick = a_wrap & phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= a_eff;
      a_cnt <= '0;
      phase <= 1'b0;
      b_cnt <= b_load;
    end else begin
      if (a_wrap) begin
        a_cnt <= '0;
        phase <= ~phase;
      end else begin
        a_cnt <= a_cnt + 1'b1;
      end
      if (fclk_tick) begin
        if (b_cnt == '0) begin
          b_cnt <= b_load;
          a_q   <= a_eff;
        end else begin
          b_cnt <= b_cnt - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= sclk_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      fs_n      <= 1'b1;
      adc_start <= 1'b0;
      adc_done  <= 1'b0;
      dac_start <= 1'b0;
      dac_done  <= 1'b0;
      dac_left  <= '0;
    end else begin
      adc_start <= fclk_tick && (b_cnt == BW'(ADC_AT + 1));
      adc_done  <= b_end;
      dac_start <= 1'b0;
      dac_done  <= 1'b0;
      if (fclk_tick && dac_left != '0) begin
        dac_left <= dac_left - 1'b1;
        if (dac_left == CW'(1)) dac_done <= 1'b1;
      end
      if (b_end) begin
        state <= S_WFALL;
        fs_n  <= 1'b1;
      end else begin
        case (state)
          S_WFALL: if (sc_fall) state <= S_WRISE;
          S_WRISE: if (sc_rise) begin
            state     <= S_LOW;
            fs_n      <= 1'b0;
            dac_start <= 1'b1;
            dac_left  <= CW'(CONV_LEN);
          end
          S_LOW: if (sc_rise) begin
            state <= S_IDLE;
            fs_n  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/codec_frame_timer_chk.sv
module codec_frame_timer_chk #(
  parameter int BW     = 8,
  parameter int BMIN   = 20,
  parameter int ADC_AT = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          fclk_tick,
  input logic [BW-1:0] b_cnt,
  input logic          adc_start,
  input logic          adc_done,
  input logic          dac_start,
  input logic          fs_n
);
  assert_b_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !fclk_tick |=> $stable(b_cnt));

  assert_adc_start_at_count_R4: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> (b_cnt == BW'(ADC_AT)));

  assert_done_reload_floor_R5: assert property (@(posedge clk) disable iff (rst)
    adc_done |-> (b_cnt >= BW'(BMIN - 1)));

  assert_adc_strobes_apart_R5: assert property (@(posedge clk) disable iff (rst)
    !(adc_start && adc_done));

  assert_dac_with_sync_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(fs_n) |-> dac_start);

  assert_frame_end_releases_sync_R7: assert property (@(posedge clk) disable iff (rst)
    adc_done |-> fs_n);
endmodule

bind codec_frame_timer codec_frame_timer_chk #(.BW(BW), .BMIN(BMIN), .ADC_AT(ADC_AT)) u_chk (
  .clk(clk), .rst(rst), .fclk_tick(fclk_tick), .b_cnt(b_cnt),
  .adc_start(adc_start), .adc_done(adc_done), .dac_start(dac_start), .fs_n(fs_n)
);

// File: tb/codec_frame_timer_tb.sv
`timescale 1ns/1ps
module codec_frame_timer_tb;
  localparam int AW = 8, BW = 8;

  logic clk = 0, rst = 1, sclk = 0;
  logic [AW-1:0] a_div = 1;
  logic [BW-1:0] b_len = 20;
  logic fclk_tick, adc_start, adc_done, dac_start, dac_done, fs_n;
  logic [BW-1:0] b_cnt;

  codec_frame_timer u_dut (
    .clk(clk), .rst(rst), .sclk_in(sclk), .a_div(a_div), .b_len(b_len),
    .fclk_tick(fclk_tick), .b_cnt(b_cnt), .adc_start(adc_start), .adc_done(adc_done),
    .dac_start(dac_start), .dac_done(dac_done), .fs_n(fs_n)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit run = 0;
  int rst_cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int eff_a(input int a);
    return (a == 0) ? 1 : a;
  endfunction
  function automatic int eff_b(input int b);
    return (b < 20) ? 20 : b;
  endfunction

  int cap_a, cap_b, last_done, last_tick;
  int adc_tk = 0, dac_tk = 0;
  bit adc_on = 0, dac_on = 0;
  int em = 0;
  bit efs = 1;
  logic [3:0] h = '0;
  int half_left = 2;
  int frames = 0;

  always @(negedge clk) begin
    if (run && cyc > rst_cyc) begin
      bit rise_m, fall_m, exp_ds, prev_efs;
      rise_m = h[2] & ~h[3];
      fall_m = ~h[2] & h[3];
      prev_efs = efs;
      exp_ds = 0;

      if (fclk_tick) begin
        chk(cyc - last_tick == 2 * cap_a, "R1 fclk period", cyc - last_tick, 2 * cap_a);
        last_tick = cyc;
      end
      if (adc_done) begin
        chk(cyc - last_done == 2 * cap_a * cap_b, "R2 frame length", cyc - last_done, 2 * cap_a * cap_b);
        chk(adc_on && adc_tk == 10, "R5 adc ticks", adc_tk, 10);
        chk(b_cnt == eff_b(b_len) - 1, "R3 reload capture", b_cnt, eff_b(b_len) - 1);
        cap_a = eff_a(a_div);
        cap_b = eff_b(b_len);
        last_done = cyc;
        adc_on = 0;
        frames++;
        em = 1;
        efs = 1;
      end else begin
        case (em)
          1: if (fall_m) em = 2;
          2: if (rise_m) begin em = 3; efs = 0; exp_ds = 1; end
          3: if (rise_m) begin em = 0; efs = 1; end
          default: ;
        endcase
      end
      if (adc_start) begin
        chk(b_cnt == 9, "R4 start count", b_cnt, 9);
        chk(cyc - last_done == 2 * cap_a * (cap_b - 10), "R4 start time",
            cyc - last_done, 2 * cap_a * (cap_b - 10));
        adc_on = 1;
        adc_tk = 0;
      end
      if (fs_n !== efs || efs != prev_efs)
        chk(fs_n === efs, efs ? "R7 sync high" : "R6 sync low", fs_n, efs);
      if (dac_start || exp_ds)
        chk(dac_start == exp_ds, "R8 dac start", dac_start, exp_ds);
      if (dac_done) begin
        chk(dac_on && dac_tk == 10, "R8 dac ticks", dac_tk, 10);
        dac_on = 0;
      end
      if (dac_start) begin
        dac_on = 1;
        dac_tk = 0;
      end
      if (fclk_tick) begin
        adc_tk++;
        dac_tk++;
      end

      half_left--;
      if (half_left == 0) begin
        sclk = ~sclk;
        half_left = $urandom_range(1, 3);
      end
      h = {h[2:0], sclk};
      if (cyc == 3000) begin
        a_div = 0;
        b_len = 5;
      end else if (cyc > 6000 && $urandom_range(0, 199) == 0) begin
        a_div = AW'($urandom_range(0, 3));
        b_len = BW'($urandom_range(0, 40));
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    a_div = 1;
    b_len = 20;
    repeat (4) @(negedge clk);
    chk(fs_n === 1'b1, "R9 reset sync", fs_n, 1);
    chk({adc_start, adc_done, dac_start, dac_done} == 4'b0, "R9 reset strobes",
        {adc_start, adc_done, dac_start, dac_done}, 0);
    chk(b_cnt == 19, "R9 reset count", b_cnt, 19);
    b_len = 7;
    @(negedge clk);
    chk(b_cnt == 19, "R9 reset clamp", b_cnt, 19);
    b_len = 20;
    @(negedge clk);
    cap_a = 1;
    cap_b = 20;
    last_done = cyc;
    last_tick = cyc - 1;
    rst_cyc = cyc;
    rst = 0;
    run = 1;
    wait (cyc >= 30000);
    @(negedge clk);
    chk(frames > 50, "R2 frame count", frames, 51);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors + 0);
    $finish;
  end

  initial begin
    #3000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 30000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule